// File: doc/BRIEF.md
# Disk Controller I/O Address Decoder

This block sits between a host I/O port and the register targets of a two-channel disk controller. Each host access carries an address, a byte count of 1, 2 or 4, and for writes a data word. The block compares the address against five programmable windows and forwards a local offset, a window code, a channel and a drive number to the target that owns the address. The five windows are primary command, primary control, secondary command, secondary control and bus-master registers.

While it decodes, the block watches writes to the drive-select register in each command window. It keeps one select bit per channel, master or slave, and uses that bit to send command and control traffic to the current drive. When that drive position is empty, the access is absorbed here: reads return zero and writes are dropped. Two configuration inputs gate the decoder. One turns all I/O decoding on or off. The other allows bus-master writes.

Every request is answered exactly one clock later. The answer is a response strobe plus either a forwarded target transaction or a flag saying why nothing was forwarded.

Top module: `hdc_io_decode`

## Requirements
- R1: While `io_en` is low, a request still gets `rsp_valid`, but nothing is forwarded, no error or zero flag is raised, and `dev_sel` keeps its value.
- R2: Windows are tried in the fixed order primary command (code 0), primary control (1), secondary command (2), secondary control (3), bus-master (4). Window i occupies slice i of `win_base` and `win_size`. It is hit when base ≤ address < base + size, and the first window hit wins.
- R3: The forwarded offset is the address minus the window base. For the primary command window this difference is then shifted right by `IO_SHIFT`. For the primary control window `CTRL_ADD` is added to it. The secondary windows use the plain difference.
- R4: A write to a command window whose offset is `SEL_OFF` (6) sets that channel's select bit to bit `SEL_BIT` (4) of the write data: 1 selects the slave, 0 the master. `dev_sel[0]` is the primary channel and `dev_sel[1]` the secondary. Nothing else changes `dev_sel`, and a write at that offset does select a drive.
- R5: Command and control accesses are routed to the drive that `dev_sel` names for that channel, after any select update made by the same write. `drive_present` bit {channel, drive} tells whether that position is filled: bit 0 primary master, bit 1 primary slave, bit 2 secondary master, bit 3 secondary slave. If the position is empty, nothing is forwarded, and a read raises `rsp_zero`.
- R6: A write that hits the bus-master window while `bm_en` is low is dropped, with no forward and no flag. Reads of the bus-master window are forwarded whatever the state of `bm_en`.
- R7: In the bus-master window, an offset below `BM_BLK` goes to channel 0 unchanged. Any other offset goes to channel 1 with `BM_BLK` subtracted.
- R8: A request whose size is not 1, 2 or 4 raises `err_size`, forwards nothing, and raises `rsp_zero` if it is a read.
- R9: A legal-size request that hits no window raises `err_miss`, forwards nothing, and raises `rsp_zero` if it is a read.
- R10: All outputs are zero after reset. Every response appears exactly one cycle after its request, and `rsp_valid` is low in any cycle that follows a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_en | input | 1 | Enables all I/O decoding |
| bm_en | input | 1 | Allows writes to the bus-master window |
| drive_present | input | 4 | Filled drive positions, index {channel, drive} |
| win_base | input | 5*AW | Base address of each window, window i in slice i |
| win_size | input | 5*AW | Size in bytes of each window |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Request address |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_zero | output | 1 | Read is answered locally with zero |
| err_miss | output | 1 | Address hit no window |
| err_size | output | 1 | Illegal access size |
| tgt_valid | output | 1 | Transaction forwarded to a target |
| tgt_write | output | 1 | Forwarded direction |
| tgt_win | output | 3 | Window code of the target |
| tgt_chan | output | 1 | Channel, 0 primary, 1 secondary |
| tgt_dev | output | 1 | Drive, 0 master, 1 slave (0 for bus-master) |
| tgt_offset | output | AW | Local offset inside the target |
| tgt_size | output | 3 | Forwarded access size |
| tgt_wdata | output | DW | Forwarded write data |
| dev_sel | output | 2 | Per-channel drive-select bits |

## Verification
The only state the block keeps is the pair of drive-select bits. A wrong select bit shows up at the next command or control access on that channel, in the same response cycle: either `tgt_dev` carries the wrong value, or a read comes back as zero from a position that should be filled. The bench therefore follows every select write with accesses that depend on it, and reads `dev_sel` back directly after writes that must leave it alone. Decode faults, such as wrong window order, an off-by-one upper bound or a wrong offset adjustment, show in the one response that follows the offending request.

// File: rtl/hdc_io_pkg.sv
package hdc_io_pkg;
    localparam int NUM_WIN = 5;
    localparam int WIN_W   = 3;

    localparam logic [WIN_W-1:0] W_PCMD = 3'd0;
    localparam logic [WIN_W-1:0] W_PCTL = 3'd1;
    localparam logic [WIN_W-1:0] W_SCMD = 3'd2;
    localparam logic [WIN_W-1:0] W_SCTL = 3'd3;
    localparam logic [WIN_W-1:0] W_BM   = 3'd4;

    function automatic logic size_legal(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction
endpackage

// File: rtl/hdc_win_cmp.sv
module hdc_win_cmp #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] size,
    output logic          hit,
    output logic [AW-1:0] offs
);
    always_comb begin
        offs = addr - base;
        hit  = (addr >= base) && (offs < size);
    end
endmodule

// File: rtl/hdc_first_hit.sv
module hdc_first_hit #(
    parameter int N  = 5,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  hits,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |hits;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/hdc_io_decode.sv
module hdc_io_decode
    import hdc_io_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 32,
    parameter int IO_SHIFT = 0,
    parameter int CTRL_ADD = 0,
    parameter int BM_BLK   = 8,
    parameter int SEL_OFF  = 6,
    parameter int SEL_BIT  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  io_en,
    input  logic                  bm_en,
    input  logic [3:0]            drive_present,
    input  logic [NUM_WIN*AW-1:0] win_base,
    input  logic [NUM_WIN*AW-1:0] win_size,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [AW-1:0]         req_addr,
    input  logic [2:0]            req_size,
    input  logic [DW-1:0]         req_wdata,
    output logic                  rsp_valid,
    output logic                  rsp_zero,
    output logic                  err_miss,
    output logic                  err_size,
    output logic                  tgt_valid,
    output logic                  tgt_write,
    output logic [WIN_W-1:0]      tgt_win,
    output logic                  tgt_chan,
    output logic                  tgt_dev,
    output logic [AW-1:0]         tgt_offset,
    output logic [2:0]            tgt_size,
    output logic [DW-1:0]         tgt_wdata,
    output logic [1:0]            dev_sel
);
    localparam logic [AW-1:0] SEL_OFF_V  = AW'(SEL_OFF);
    localparam logic [AW-1:0] CTRL_ADD_V = AW'(CTRL_ADD);
    localparam logic [AW-1:0] BM_BLK_V   = AW'(BM_BLK);

    typedef struct packed {
        logic             rsp_valid;
        logic             rsp_zero;
        logic             err_miss;
        logic             err_size;
        logic             tgt_valid;
        logic             tgt_write;
        logic [WIN_W-1:0] win;
        logic             chan;
        logic             dev;
        logic [AW-1:0]    off;
        logic [2:0]       size;
        logic [DW-1:0]    wdata;
        logic [1:0]       dsel;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_WIN-1:0] hits;
    logic [AW-1:0]      offs [NUM_WIN];
    logic               found;
    logic [WIN_W-1:0]   idx;

    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : gen_win
        hdc_win_cmp #(.AW(AW)) u_cmp (
            .addr (req_addr),
            .base (win_base[gi*AW +: AW]),
            .size (win_size[gi*AW +: AW]),
            .hit  (hits[gi]),
            .offs (offs[gi])
        );
    end

    hdc_first_hit #(.N(NUM_WIN), .IW(WIN_W)) u_pick (
        .hits  (hits),
        .found (found),
        .idx   (idx)
    );

    logic [AW-1:0] raw_off;
    logic [AW-1:0] loc_off;
    logic          ch;
    logic          dv;
    logic          is_cmd;

    always_comb begin
        raw_off = offs[0];
        for (int i = 0; i < NUM_WIN; i++) begin
            if (idx == WIN_W'(i)) raw_off = offs[i];
        end
    end

    always_comb begin
        state_d           = state_q;
        state_d.rsp_valid = req_valid;
        state_d.rsp_zero  = 1'b0;
        state_d.err_miss  = 1'b0;
        state_d.err_size  = 1'b0;
        state_d.tgt_valid = 1'b0;
        state_d.tgt_write = req_write;
        state_d.win       = idx;
        state_d.chan      = 1'b0;
        state_d.dev       = 1'b0;
        state_d.off       = '0;
        state_d.size      = req_size;
        state_d.wdata     = req_wdata;
        ch                = (idx == W_SCMD) || (idx == W_SCTL);
        is_cmd            = (idx == W_PCMD) || (idx == W_SCMD);
        loc_off           = raw_off;
        dv                = 1'b0;

        if (idx == W_PCMD) loc_off = raw_off >> IO_SHIFT;
        else if (idx == W_PCTL) loc_off = raw_off + CTRL_ADD_V;

        if (req_valid && io_en) begin
            if (!size_legal(req_size)) begin
                state_d.err_size = 1'b1;
                state_d.rsp_zero = !req_write;
            end else if (!found) begin
                state_d.err_miss = 1'b1;
                state_d.rsp_zero = !req_write;
            end else if (idx == W_BM) begin
                if (!(req_write && !bm_en)) begin
                    state_d.tgt_valid = 1'b1;
                    if (raw_off < BM_BLK_V) begin
                        state_d.chan = 1'b0;
                        state_d.off  = raw_off;
                    end else begin
                        state_d.chan = 1'b1;
                        state_d.off  = raw_off - BM_BLK_V;
                    end
                end
            end else begin
                if (is_cmd && req_write && (loc_off == SEL_OFF_V)) begin
                    state_d.dsel[ch] = req_wdata[SEL_BIT];
                end
                dv           = state_d.dsel[ch];
                state_d.chan = ch;
                state_d.dev  = dv;
                state_d.off  = loc_off;
                if (drive_present[{ch, dv}]) begin
                    state_d.tgt_valid = 1'b1;
                end else begin
                    state_d.rsp_zero = !req_write;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rsp_valid  = state_q.rsp_valid;
    assign rsp_zero   = state_q.rsp_zero;
    assign err_miss   = state_q.err_miss;
    assign err_size   = state_q.err_size;
    assign tgt_valid  = state_q.tgt_valid;
    assign tgt_write  = state_q.tgt_write;
    assign tgt_win    = state_q.win;
    assign tgt_chan   = state_q.chan;
    assign tgt_dev    = state_q.dev;
    assign tgt_offset = state_q.off;
    assign tgt_size   = state_q.size;
    assign tgt_wdata  = state_q.wdata;
    assign dev_sel    = state_q.dsel;
endmodule

// File: rtl/hdc_io_decode_chk.sv
module hdc_io_decode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       io_en,
    input logic       req_valid,
    input logic       req_write,
    input logic [2:0] req_size,
    input logic       rsp_valid,
    input logic       rsp_zero,
    input logic       err_miss,
    input logic       err_size,
    input logic       tgt_valid,
    input logic [1:0] dev_sel
);
    a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r1_io_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !io_en) |=> (!tgt_valid && !err_miss && !err_size && !rsp_zero));

    a_r1_io_off_keeps_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !io_en) |=> $stable(dev_sel));

    a_r4_sel_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && io_en) |=> $stable(dev_sel));

    a_r8_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && io_en && !(req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4))
        |=> (err_size && !tgt_valid));

    a_r9_err_blocks_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (err_miss || err_size) |-> (!tgt_valid && !(err_miss && err_size)));

    a_r5_fwd_not_zero: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> !rsp_zero);
endmodule

bind hdc_io_decode hdc_io_decode_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_en     (io_en),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_zero  (rsp_zero),
    .err_miss  (err_miss),
    .err_size  (err_size),
    .tgt_valid (tgt_valid),
    .dev_sel   (dev_sel)
);

// File: tb/hdc_io_decode_bench.sv
module hdc_io_decode_bench;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          io_en = 1'b0;
    logic          bm_en = 1'b0;
    logic [3:0]    drive_present = 4'b0111;
    logic [5*AW-1:0] win_base = '0;
    logic [5*AW-1:0] win_size = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]    req_size = 3'd1;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid, rsp_zero, err_miss, err_size;
    logic          tgt_valid, tgt_write, tgt_chan, tgt_dev;
    logic [2:0]    tgt_win, tgt_size;
    logic [AW-1:0] tgt_offset;
    logic [DW-1:0] tgt_wdata;
    logic [1:0]    dev_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hdc_io_decode #(.AW(AW), .DW(DW), .IO_SHIFT(1), .CTRL_ADD(2), .BM_BLK(8)) u_hdc_io_decode (
        .clk(clk), .rst_n(rst_n), .io_en(io_en), .bm_en(bm_en),
        .drive_present(drive_present), .win_base(win_base), .win_size(win_size),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_zero(rsp_zero), .err_miss(err_miss),
        .err_size(err_size), .tgt_valid(tgt_valid), .tgt_write(tgt_write),
        .tgt_win(tgt_win), .tgt_chan(tgt_chan), .tgt_dev(tgt_dev),
        .tgt_offset(tgt_offset), .tgt_size(tgt_size), .tgt_wdata(tgt_wdata),
        .dev_sel(dev_sel)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [2:0]  size;
        logic [31:0] wdata;
        logic        ev;
        logic [2:0]  ewin;
        logic        ech;
        logic        edev;
        logic [15:0] eoff;
        logic        ezero;
        logic        emiss;
        logic        ebad;
        logic [1:0]  edsel;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'h0104, 3'd1, 32'h0,  1'b1, 3'd0, 1'b0, 1'b0, 16'd2, 1'b0, 1'b0, 1'b0, 2'b00},
        '{1'b1, 16'h010C, 3'd1, 32'h10, 1'b1, 3'd0, 1'b0, 1'b1, 16'd6, 1'b0, 1'b0, 1'b0, 2'b01},
        '{1'b0, 16'h0121, 3'd1, 32'h0,  1'b1, 3'd1, 1'b0, 1'b1, 16'd3, 1'b0, 1'b0, 1'b0, 2'b01},
        '{1'b0, 16'h0147, 3'd2, 32'h0,  1'b1, 3'd2, 1'b1, 1'b0, 16'd7, 1'b0, 1'b0, 1'b0, 2'b01},
        '{1'b1, 16'h0146, 3'd1, 32'h10, 1'b0, 3'd0, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0, 1'b0, 2'b11},
        '{1'b0, 16'h0140, 3'd1, 32'h0,  1'b0, 3'd0, 1'b0, 1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 2'b11},
        '{1'b1, 16'h0146, 3'd1, 32'hA0, 1'b1, 3'd2, 1'b1, 1'b0, 16'd6, 1'b0, 1'b0, 1'b0, 2'b01},
        '{1'b0, 16'h0152, 3'd1, 32'h0,  1'b1, 3'd3, 1'b1, 1'b0, 16'd2, 1'b0, 1'b0, 1'b0, 2'b01},
        '{1'b0, 16'h0162, 3'd1, 32'h0,  1'b1, 3'd4, 1'b0, 1'b0, 16'd2, 1'b0, 1'b0, 1'b0, 2'b01},
        '{1'b1, 16'h016A, 3'd4, 32'h5,  1'b1, 3'd4, 1'b1, 1'b0, 16'd2, 1'b0, 1'b0, 1'b0, 2'b01},
        '{1'b0, 16'h0200, 3'd1, 32'h0,  1'b0, 3'd0, 1'b0, 1'b0, 16'd0, 1'b1, 1'b1, 1'b0, 2'b01},
        '{1'b0, 16'h0104, 3'd3, 32'h0,  1'b0, 3'd0, 1'b0, 1'b0, 16'd0, 1'b1, 1'b0, 1'b1, 2'b01},
        '{1'b1, 16'h010C, 3'd1, 32'hEF, 1'b1, 3'd0, 1'b0, 1'b0, 16'd6, 1'b0, 1'b0, 1'b0, 2'b00},
        '{1'b0, 16'h0110, 3'd1, 32'h0,  1'b0, 3'd0, 1'b0, 1'b0, 16'd0, 1'b1, 1'b1, 1'b0, 2'b00},
        '{1'b0, 16'h010F, 3'd1, 32'h0,  1'b1, 3'd0, 1'b0, 1'b0, 16'd7, 1'b0, 1'b0, 1'b0, 2'b00},
        '{1'b0, 16'h016F, 3'd1, 32'h0,  1'b1, 3'd4, 1'b1, 1'b0, 16'd7, 1'b0, 1'b0, 1'b0, 2'b00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_win(input int i, input logic [15:0] b, input logic [15:0] s);
        win_base[i*AW +: AW] = b;
        win_size[i*AW +: AW] = s;
    endtask

    task automatic issue(input logic wr, input logic [15:0] a, input logic [2:0] sz,
                         input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_size  = sz;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        set_win(0, 16'h0100, 16'h0010);
        set_win(1, 16'h0120, 16'h0004);
        set_win(2, 16'h0140, 16'h0008);
        set_win(3, 16'h0150, 16'h0004);
        set_win(4, 16'h0160, 16'h0010);
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R10 reset tgt_valid", 32'(tgt_valid), 32'd0);
        chk("R10 reset dev_sel", 32'(dev_sel), 32'd0);
        chk("R10 reset flags", 32'({rsp_zero, err_miss, err_size}), 32'd0);
        rst_n = 1'b1;
        io_en = 1'b1;
        bm_en = 1'b1;

        // table walk: R2 R3 R4 R5 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            issue(VEC[v].wr, VEC[v].addr, VEC[v].size, VEC[v].wdata);
            chk($sformatf("R10 vec%0d rsp_valid", v), 32'(rsp_valid), 32'd1);
            chk($sformatf("R2 vec%0d tgt_valid", v), 32'(tgt_valid), 32'(VEC[v].ev));
            if (VEC[v].ev) begin
                chk($sformatf("R2 vec%0d win", v), 32'(tgt_win), 32'(VEC[v].ewin));
                chk($sformatf("R7 vec%0d chan", v), 32'(tgt_chan), 32'(VEC[v].ech));
                chk($sformatf("R5 vec%0d dev", v), 32'(tgt_dev), 32'(VEC[v].edev));
                chk($sformatf("R3 vec%0d offset", v), 32'(tgt_offset), 32'(VEC[v].eoff));
                chk($sformatf("R3 vec%0d size", v), 32'(tgt_size), 32'(VEC[v].size));
            end
            chk($sformatf("R5 vec%0d zero", v), 32'(rsp_zero), 32'(VEC[v].ezero));
            chk($sformatf("R9 vec%0d miss", v), 32'(err_miss), 32'(VEC[v].emiss));
            chk($sformatf("R8 vec%0d bad size", v), 32'(err_size), 32'(VEC[v].ebad));
            chk($sformatf("R4 vec%0d dev_sel", v), 32'(dev_sel), 32'(VEC[v].edsel));
        end

        // R10: idle cycle has no response
        @(negedge clk);
        chk("R10 idle rsp_valid", 32'(rsp_valid), 32'd0);

        // R1: decoding off
        io_en = 1'b0;
        issue(1'b1, 16'h010C, 3'd1, 32'h10);
        chk("R1 off rsp_valid", 32'(rsp_valid), 32'd1);
        chk("R1 off tgt_valid", 32'(tgt_valid), 32'd0);
        chk("R1 off dev_sel", 32'(dev_sel), 32'd0);
        issue(1'b0, 16'h0200, 3'd1, 32'h0);
        chk("R1 off miss flags", 32'({rsp_zero, err_miss, err_size}), 32'd0);
        io_en = 1'b1;

        // R6: bus-master writes gated
        bm_en = 1'b0;
        issue(1'b1, 16'h0162, 3'd1, 32'h1);
        chk("R6 bm write dropped", 32'(tgt_valid), 32'd0);
        chk("R6 bm write no flag", 32'({rsp_zero, err_miss, err_size}), 32'd0);
        issue(1'b0, 16'h0162, 3'd1, 32'h0);
        chk("R6 bm read passes", 32'(tgt_valid), 32'd1);
        chk("R6 bm read win", 32'(tgt_win), 32'd4);
        bm_en = 1'b1;

        // R2: overlapping windows, first in order wins
        set_win(2, 16'h0100, 16'h0008);
        set_win(3, 16'h0160, 16'h0004);
        issue(1'b0, 16'h0102, 3'd1, 32'h0);
        chk("R2 overlap pcmd over scmd", 32'(tgt_win), 32'd0);
        chk("R2 overlap pcmd offset", 32'(tgt_offset), 32'd1);
        issue(1'b0, 16'h0161, 3'd1, 32'h0);
        chk("R2 overlap sctl over bm", 32'(tgt_win), 32'd3);
        chk("R2 overlap sctl chan", 32'(tgt_chan), 32'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule